// File: doc/BRIEF.md
# National Decimal to Signed Packed BCD Converter

This block takes a 128-bit operand made of eight 16-bit national decimal characters and turns it into a signed packed BCD word and a one-hot condition code. The lowest character carries the sign. The seven characters above it carry one decimal digit each, coded as 0x0030 through 0x0039. The result places each digit in the nibble whose index matches its character index. Nibble 0 holds a sign code. A select input picks which of the two positive sign codes is used.

The block is a single registered stage. An operand offered with `validIn` high appears on the outputs one clock later, with `validOut` high. While `validIn` is low the last result stays on the outputs. The condition code gives the sign and zero status of a good operand. For a malformed operand it gives a lone invalid flag instead.

Top module: `natdec_bcd_pack`

## Requirements
- R1: Character k occupies `natIn[16k+15:16k]`. Character 0 is the sign and characters 1 to 7 are digits. A digit character is good only when it lies in 0x0030..0x0039, and its low nibble goes to `bcdOut[4k+3:4k]`.
- R2: The sign nibble `bcdOut[3:0]` is 0xC when the sign character is 0x002B and `prefSign` is 0. It is 0xF when the sign character is 0x002B and `prefSign` is 1. It is 0xD for every other sign character, including an invalid one.
- R3: When the sign character is neither 0x002B nor 0x002D, or any digit character is out of range, `ccOut` is 4'b0001 (invalid flag alone).
- R4: When the lowest-numbered bad digit sits at character j, the nibbles for positions j..7 are zero. The good digits below j are still packed.
- R5: For a good operand with any digit character other than 0x0030, `ccOut` is 4'b0100 (greater) for a plus sign and 4'b1000 (less) for a minus sign.
- R6: For a good operand whose digit characters are all 0x0030, `ccOut` is 4'b0010 (equal), whatever the sign.
- R7: `bcdOut[127:32]` is always zero.
- R8: `validOut` and the outputs update on the clock edge after `validIn` is high. If `validIn` is low, `validOut` is low on the next cycle and `bcdOut`/`ccOut` keep their values.
- R9: Synchronous reset drives `bcdOut`, `ccOut` and `validOut` to zero.
- R10: `ccOut`, packed as {less, greater, equal, invalid} from bit 3 down to bit 0, has exactly one bit set whenever `validOut` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| validIn | input | 1 | Operand present this cycle |
| prefSign | input | 1 | Plus sign code select: 0 gives 0xC, 1 gives 0xF |
| natIn | input | 128 | Eight national characters, sign in the lowest |
| validOut | output | 1 | Result registered from the previous cycle's operand |
| bcdOut | output | 128 | Signed packed BCD result |
| ccOut | output | 4 | Condition code {less, greater, equal, invalid} |

## Verification
The assertions assume that `validIn` and `prefSign` are never unknown at a rising edge. They also assume that reset is held for at least one edge before the first operand, because the checks on sign code and on holding values compare each cycle with the one before it. The bench changes every input on falling edges only. It asserts reset from time zero and gives known values to `natIn`, `prefSign` and `validIn` before reset is released. Between operands it puts scrambled data on `natIn`, so a result that leaks through while `validIn` is low shows up at the ports.

// File: rtl/natdec_pkg.sv
package natdec_pkg;

  localparam int DEF_CHAR_W    = 16;
  localparam int DEF_NUM_CHARS = 8;
  localparam int NIB_W         = 4;

  // character codes
  localparam logic [15:0] SGN_PLUS  = 16'h002B;
  localparam logic [15:0] SGN_MINUS = 16'h002D;
  localparam logic [15:0] DIG_LO    = 16'h0030;
  localparam logic [15:0] DIG_HI    = 16'h0039;

  // packed sign nibbles
  localparam logic [3:0] NIB_PLUS_A = 4'hC;
  localparam logic [3:0] NIB_PLUS_B = 4'hF;
  localparam logic [3:0] NIB_MINUS  = 4'hD;

  typedef struct packed {
    logic capture;
    logic clear;
  } strobe_t;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cc_t;

endpackage

// File: rtl/natdec_ctrl.sv
module natdec_ctrl
  import natdec_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    validIn,
  output strobe_t strobes,
  output logic    validOut
);

  always_comb begin
    strobes.capture = validIn;
    strobes.clear   = rst;
  end

  always_ff @(posedge clk) begin
    if (rst) validOut <= 1'b0;
    else     validOut <= validIn;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    validIn |=> validOut);  // R8
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !validIn |=> !validOut);  // R8

endmodule

// File: rtl/natdec_dpath.sv
module natdec_dpath
  import natdec_pkg::*;
#(
  parameter int CHAR_W    = DEF_CHAR_W,
  parameter int NUM_CHARS = DEF_NUM_CHARS
) (
  input  logic                        clk,
  input  logic                        rst,
  input  strobe_t                     strobes,
  input  logic                        prefSign,
  input  logic [CHAR_W*NUM_CHARS-1:0] natIn,
  output logic [CHAR_W*NUM_CHARS-1:0] bcdOut,
  output cc_t                         ccOut
);

  localparam int WORD_W = CHAR_W * NUM_CHARS;
  localparam int DIG_W  = NIB_W * NUM_CHARS;

  logic [CHAR_W-1:0]    signChar;
  logic                 signPlus;
  logic                 signMinus;
  logic [NIB_W-1:0]     signNib;
  logic [NUM_CHARS-1:1] charOk;
  logic [NUM_CHARS-1:1] prefixOk;
  logic [NUM_CHARS-1:1] digNz;
  logic [DIG_W-1:0]     packedDig;
  logic                 operandOk;
  cc_t                  nextCc;
  logic [WORD_W-1:0]    nextWord;

  assign signChar  = natIn[CHAR_W-1:0];
  assign signPlus  = (signChar == CHAR_W'(SGN_PLUS));
  assign signMinus = (signChar == CHAR_W'(SGN_MINUS));
  assign signNib   = signPlus ? (prefSign ? NIB_PLUS_B : NIB_PLUS_A) : NIB_MINUS;

  assign packedDig[NIB_W-1:0] = signNib;

  // per-character range check and nibble extraction
  generate
    for (genvar i = 1; i < NUM_CHARS; i++) begin : g_dig
      logic [CHAR_W-1:0] ch;
      assign ch        = natIn[i*CHAR_W +: CHAR_W];
      assign charOk[i] = (ch >= CHAR_W'(DIG_LO)) && (ch <= CHAR_W'(DIG_HI));
      assign digNz[i]  = (ch != CHAR_W'(DIG_LO));
      assign packedDig[i*NIB_W +: NIB_W] = prefixOk[i] ? ch[NIB_W-1:0] : '0;
    end
  endgenerate

  // a digit is kept only if it and every lower digit are good
  always_comb begin : p_prefix
    logic run;
    run      = 1'b1;
    prefixOk = '0;
    for (int i = 1; i < NUM_CHARS; i++) begin
      run         = run & charOk[i];
      prefixOk[i] = run;
    end
  end

  assign operandOk = (signPlus | signMinus) & prefixOk[NUM_CHARS-1];

  always_comb begin
    nextCc = '0;
    if (!operandOk)   nextCc.so = 1'b1;
    else if (|digNz)  begin
      if (signPlus)   nextCc.gt = 1'b1;
      else            nextCc.lt = 1'b1;
    end
    else              nextCc.eq = 1'b1;
  end

  assign nextWord = WORD_W'(packedDig);

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      bcdOut <= '0;
      ccOut  <= '0;
    end else if (strobes.capture) begin
      bcdOut <= nextWord;
      ccOut  <= nextCc;
    end
  end

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    bcdOut[WORD_W-1:DIG_W] == '0);  // R7
  AST_BAD_SIGN: assert property (@(posedge clk) disable iff (rst)
    (strobes.capture && !signPlus && !signMinus) |=> (ccOut == 4'b0001));  // R3
  AST_PLUS_CODE: assert property (@(posedge clk) disable iff (rst)
    (strobes.capture && signPlus) |=>
      (bcdOut[NIB_W-1:0] == ($past(prefSign) ? NIB_PLUS_B : NIB_PLUS_A)));  // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !strobes.capture |=> ($stable(bcdOut) && $stable(ccOut)));  // R8

endmodule

// File: rtl/natdec_bcd_pack.sv
module natdec_bcd_pack
  import natdec_pkg::*;
#(
  parameter int CHAR_W    = DEF_CHAR_W,
  parameter int NUM_CHARS = DEF_NUM_CHARS
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        validIn,
  input  logic                        prefSign,
  input  logic [CHAR_W*NUM_CHARS-1:0] natIn,
  output logic                        validOut,
  output logic [CHAR_W*NUM_CHARS-1:0] bcdOut,
  output logic [3:0]                  ccOut
);

  strobe_t strobes;
  cc_t     ccReg;

  natdec_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .validIn  (validIn),
    .strobes  (strobes),
    .validOut (validOut)
  );

  natdec_dpath #(
    .CHAR_W    (CHAR_W),
    .NUM_CHARS (NUM_CHARS)
  ) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .prefSign (prefSign),
    .natIn    (natIn),
    .bcdOut   (bcdOut),
    .ccOut    (ccReg)
  );

  assign ccOut = ccReg;

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    validOut |-> ($countones(ccOut) == 1));  // R10

endmodule

// File: tb/natdec_bcd_pack_test.sv
`timescale 1ns/1ps
module natdec_bcd_pack_test;

  localparam logic [3:0] CC_LT = 4'b1000;
  localparam logic [3:0] CC_GT = 4'b0100;
  localparam logic [3:0] CC_EQ = 4'b0010;
  localparam logic [3:0] CC_SO = 4'b0001;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         validIn = 1'b0;
  logic         prefSign = 1'b0;
  logic [127:0] natIn = '0;
  logic         validOut;
  logic [127:0] bcdOut;
  logic [3:0]   ccOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  natdec_bcd_pack uut (
    .clk      (clk),
    .rst      (rst),
    .validIn  (validIn),
    .prefSign (prefSign),
    .natIn    (natIn),
    .validOut (validOut),
    .bcdOut   (bcdOut),
    .ccOut    (ccOut)
  );

  function automatic logic [127:0] mkNat(logic [15:0] s, logic [6:0][15:0] d);
    return {d, s};
  endfunction

  // digit characters 1..7 in characters 1..7
  localparam logic [6:0][15:0] SEQ17 =
    {16'h0037, 16'h0036, 16'h0035, 16'h0034, 16'h0033, 16'h0032, 16'h0031};
  localparam logic [6:0][15:0] ZEROS =
    {16'h0030, 16'h0030, 16'h0030, 16'h0030, 16'h0030, 16'h0030, 16'h0030};

  task automatic checkVal(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkResult(string tag, logic [31:0] expDig, logic [3:0] expCc);
    checkVal({tag, " R8 validOut"}, 128'(validOut), 128'(1'b1));
    checkVal({tag, " bcdOut"}, bcdOut, {96'h0, expDig});
    checkVal({tag, " ccOut"}, 128'(ccOut), 128'(expCc));
    checkVal({tag, " R10 one flag"}, 128'($countones(ccOut)), 128'(1));
  endtask

  task automatic runOp(string tag, logic [127:0] nat, logic pref,
                       logic [31:0] expDig, logic [3:0] expCc);
    @(negedge clk);
    natIn = nat; prefSign = pref; validIn = 1'b1;
    @(negedge clk);
    validIn = 1'b0; natIn = ~nat; prefSign = ~pref;
    checkResult(tag, expDig, expCc);
  endtask

  task automatic testReset();
    runOp("R1 R5 pre-reset", mkNat(16'h002B, SEQ17), 1'b0, 32'h7654321C, CC_GT);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    checkVal("R9 validOut", 128'(validOut), 128'(0));
    checkVal("R9 bcdOut", bcdOut, 128'(0));
    checkVal("R9 ccOut", 128'(ccOut), 128'(0));
  endtask

  task automatic testPlus();
    runOp("R1 R2 R5 R7 plus pref0", mkNat(16'h002B, SEQ17), 1'b0, 32'h7654321C, CC_GT);
    runOp("R2 plus pref1", mkNat(16'h002B, SEQ17), 1'b1, 32'h7654321F, CC_GT);
  endtask

  task automatic testMinus();
    logic [6:0][15:0] d = ZEROS;
    d[0] = 16'h0039;
    runOp("R2 R5 minus low digit", mkNat(16'h002D, d), 1'b1, 32'h0000009D, CC_LT);
    d = ZEROS; d[6] = 16'h0038;
    runOp("R1 R5 minus top digit", mkNat(16'h002D, d), 1'b0, 32'h8000000D, CC_LT);
  endtask

  task automatic testZero();
    runOp("R6 plus zero", mkNat(16'h002B, ZEROS), 1'b0, 32'h0000000C, CC_EQ);
    runOp("R6 minus zero", mkNat(16'h002D, ZEROS), 1'b1, 32'h0000000D, CC_EQ);
  endtask

  task automatic testBadSign();
    runOp("R3 R2 bad sign", mkNat(16'h0041, SEQ17), 1'b0, 32'h7654321D, CC_SO);
    runOp("R3 R2 sign high byte", mkNat(16'h012B, ZEROS), 1'b1, 32'h0000000D, CC_SO);
  endtask

  task automatic testBadDigit();
    logic [6:0][15:0] d = SEQ17;
    d[3] = 16'h003A;
    runOp("R4 R3 bad char4", mkNat(16'h002B, d), 1'b0, 32'h0000321C, CC_SO);
    d = SEQ17; d[0] = 16'h002F;
    runOp("R4 R3 bad char1", mkNat(16'h002D, d), 1'b0, 32'h0000000D, CC_SO);
    d = SEQ17; d[6] = 16'h0135;
    runOp("R4 R3 bad char7", mkNat(16'h002B, d), 1'b1, 32'h0654321F, CC_SO);
  endtask

  task automatic testHold();
    runOp("R8 hold setup", mkNat(16'h002B, SEQ17), 1'b0, 32'h7654321C, CC_GT);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      natIn = mkNat(16'h002D, ZEROS);
      checkVal("R8 idle validOut", 128'(validOut), 128'(0));
      checkVal("R8 idle bcdOut", bcdOut, {96'h0, 32'h7654321C});
      checkVal("R8 idle ccOut", 128'(ccOut), 128'(CC_GT));
    end
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    natIn = mkNat(16'h002D, SEQ17); prefSign = 1'b0; validIn = 1'b1;
    @(negedge clk);
    checkResult("R8 first of pair", 32'h7654321D, CC_LT);
    natIn = mkNat(16'h002B, ZEROS); prefSign = 1'b1;
    @(negedge clk);
    validIn = 1'b0;
    checkResult("R8 second of pair", 32'h0000000F, CC_EQ);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    checkVal("R9 initial validOut", 128'(validOut), 128'(0));
    checkVal("R9 initial bcdOut", bcdOut, 128'(0));
    testPlus();
    testMinus();
    testZero();
    testBadSign();
    testBadDigit();
    testHold();
    testBackToBack();
    testReset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule